// File: doc/BRIEF.md
# Branch Flush and Delay-Slot Controller

This block is the pipeline control unit that handles taken branches in a three-stage in-order core with fetch, decode and execute stages and a prefetch buffer. When a branch in execute is taken, the block raises a redirect carrying the computed target. It also raises flushes for the younger instructions. What gets flushed depends on the branch kind. An ordinary branch discards everything younger than itself. A branch with a delay slot discards only the fetch stage, so the instruction already in decode still executes.

While a delayed branch and its slot are in flight, the block holds back pending interrupts and external hardware break requests. It releases them on the first cycle after the slot instruction retires. At the moment the branch is taken, it inspects the class flags of the decode-stage instruction and flags the slot as illegal if that instruction is forbidden there.

When an exception is raised by the slot instruction, the block sets a delay-slot status bit and saves the branch target, so the handler can resume at the target. When an exception is raised outside a slot, the block clears that bit and records the address after the faulting instruction as a valid return address.

Top module: `branch_flush_ctrl`

## Requirements
- R1: In a cycle where `ex_valid` and `ex_taken` are high and `ex_delayed` is low, `flush_pfb`, `flush_fetch` and `flush_decode` are all high in that same cycle.
- R2: `redirect_valid` is high exactly in cycles where `ex_valid` and `ex_taken` are high, and `redirect_pc` then equals `ex_target`.
- R3: A taken branch refills two stages (`flush_fetch` and `flush_decode` both high) without a delay slot, and one stage (`flush_fetch` only) with a delay slot.
- R4: A taken delayed branch (`ex_valid`, `ex_taken` and `ex_delayed` all high) raises `flush_fetch` only. `flush_decode` and `flush_pfb` stay low, so the decode instruction becomes the slot.
- R5: When `ex_valid` or `ex_taken` is low, all three flushes and `redirect_valid` are low. This applies to a not-taken delayed branch, whose slot proceeds normally.
- R6: `slot_illegal` is high in the cycle of a taken delayed branch when `dec_valid` is high and any of `dec_is_imm`, `dec_is_branch` or `dec_is_brk` is high. It is low in every other cycle.
- R7: `slot_active` is high from the cycle after a taken delayed branch until the first later cycle in which `ex_valid` is high, which is the cycle the slot retires. `irq_take` and `brk_take` are low during the branch cycle and whenever `slot_active` is high.
- R8: In any cycle with neither a taken delayed branch nor `slot_active`, `irq_take` equals `irq_req` and `brk_take` equals `brk_req`. A request pending across a slot is therefore accepted on the first cycle after the slot retires.
- R9: An exception (`ex_valid` and `ex_exception` high) while `slot_active` is high has these effects from the next cycle: `esr_ds` is 1, `btr` holds the target of the delayed branch, and `ret_addr_valid` is 0.
- R10: An exception while `slot_active` is low has these effects from the next cycle: `esr_ds` is 0, `ret_addr` holds `ex_pc_next`, `ret_addr_valid` is 1, and `btr` is unchanged.
- R11: After reset, `slot_active`, `esr_ds`, `ret_addr_valid`, `btr` and `ret_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ex_valid | input | 1 | Execute stage holds an instruction that completes this cycle |
| ex_taken | input | 1 | The execute instruction is a branch resolved as taken |
| ex_delayed | input | 1 | The execute branch has a delay slot |
| ex_target | input | AW | Computed branch target |
| ex_exception | input | 1 | The execute instruction raises an exception |
| ex_pc_next | input | AW | Address following the execute instruction |
| dec_valid | input | 1 | Decode stage holds an instruction |
| dec_is_imm | input | 1 | The decode instruction is an immediate prefix |
| dec_is_branch | input | 1 | The decode instruction is a branch |
| dec_is_brk | input | 1 | The decode instruction is a break |
| irq_req | input | 1 | Interrupt pending |
| brk_req | input | 1 | External hardware break pending |
| flush_pfb | output | 1 | Flush the prefetch buffer |
| flush_fetch | output | 1 | Flush the fetch stage |
| flush_decode | output | 1 | Flush the decode stage |
| redirect_valid | output | 1 | Reload fetch from redirect_pc |
| redirect_pc | output | AW | Fetch reload address |
| slot_active | output | 1 | A delay-slot instruction is awaiting retirement |
| slot_illegal | output | 1 | A forbidden instruction sits in the delay slot |
| irq_take | output | 1 | Interrupt accepted this cycle |
| brk_take | output | 1 | External break accepted this cycle |
| esr_ds | output | 1 | Last exception came from a delay slot |
| btr | output | AW | Saved branch target for slot exceptions |
| ret_addr | output | AW | Address after the last non-slot faulting instruction |
| ret_addr_valid | output | 1 | ret_addr is meaningful |

## Verification
Directed cases cover each branch kind once. An ordinary taken branch and a delayed taken branch are distinguished by which flushes they raise. A delayed branch that is not taken is checked to raise no flush and to arm no slot. One slot case stalls with `ex_valid` low, which shows that the slot stays open until real retirement and not merely until the next cycle. Slot instructions of each forbidden class, and a legal one, are checked for the illegal flag. Exceptions placed inside and outside a slot are checked for the two capture outcomes. Random traffic mixes these cases with requests held across slots, so that back-to-back branches, exceptions during stalls and the exact cycle of interrupt acceptance are checked against a cycle model in the bench.

// File: rtl/bfc_pkg.sv
package bfc_pkg;

  typedef struct packed {
    logic pfb;
    logic fetch;
    logic decode;
  } flush_t;

  // Flush set for a resolved branch in execute.
  function automatic flush_t flush_for(input logic taken, input logic delayed);
    flush_t f;
    f.fetch  = taken;
    f.decode = taken & ~delayed;
    f.pfb    = taken & ~delayed;
    return f;
  endfunction

  // Instruction classes that may not occupy a delay slot.
  function automatic logic slot_forbidden(input logic imm, input logic br, input logic brk);
    return imm | br | brk;
  endfunction

  // Next state of the slot-open flag.
  function automatic logic slot_next(input logic arm, input logic open, input logic retire);
    logic n;
    if (arm)         n = 1'b1;
    else if (retire) n = 1'b0;
    else             n = open;
    return n;
  endfunction

endpackage

// File: rtl/bfc_flush_unit.sv
module bfc_flush_unit
  import bfc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          ex_valid,
  input  logic          ex_taken,
  input  logic          ex_delayed,
  input  logic [AW-1:0] ex_target,
  output flush_t        flush,
  output logic          redirect_valid,
  output logic [AW-1:0] redirect_pc,
  output logic          arm_slot
);

  logic take;

  always_comb begin
    take           = ex_valid & ex_taken;
    flush          = flush_for(take, ex_delayed);
    redirect_valid = take;
    redirect_pc    = ex_target;
    arm_slot       = take & ex_delayed;
  end

endmodule

// File: rtl/bfc_slot_tracker.sv
module bfc_slot_tracker
  import bfc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_slot,
  input  logic [AW-1:0] arm_target,
  input  logic          ex_valid,
  input  logic          dec_valid,
  input  logic          dec_is_imm,
  input  logic          dec_is_branch,
  input  logic          dec_is_brk,
  output logic          slot_active,
  output logic          slot_retire,
  output logic [AW-1:0] slot_tgt,
  output logic          slot_illegal
);

  always_comb begin
    slot_retire  = slot_active & ex_valid;
    slot_illegal = arm_slot & dec_valid & slot_forbidden(dec_is_imm, dec_is_branch, dec_is_brk);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_active <= 1'b0;
      slot_tgt    <= '0;
    end else begin
      slot_active <= slot_next(arm_slot, slot_active, slot_retire);
      if (arm_slot) slot_tgt <= arm_target;
    end
  end

endmodule

// File: rtl/bfc_event_gate.sv
module bfc_event_gate (
  input  logic arm_slot,
  input  logic slot_active,
  input  logic irq_req,
  input  logic brk_req,
  output logic defer,
  output logic irq_take,
  output logic brk_take
);

  always_comb begin
    defer    = arm_slot | slot_active;
    irq_take = irq_req & ~defer;
    brk_take = brk_req & ~defer;
  end

endmodule

// File: rtl/bfc_exc_capture.sv
module bfc_exc_capture #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exc_fire,
  input  logic          in_slot,
  input  logic [AW-1:0] slot_tgt,
  input  logic [AW-1:0] pc_next,
  output logic          esr_ds,
  output logic [AW-1:0] btr,
  output logic [AW-1:0] ret_addr,
  output logic          ret_addr_valid
);

  logic seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      esr_ds   <= 1'b0;
      btr      <= '0;
      ret_addr <= '0;
      seen     <= 1'b0;
    end else if (exc_fire) begin
      seen <= 1'b1;
      if (in_slot) begin
        esr_ds <= 1'b1;
        btr    <= slot_tgt;
      end else begin
        esr_ds   <= 1'b0;
        ret_addr <= pc_next;
      end
    end
  end

  assign ret_addr_valid = seen & ~esr_ds;

endmodule

// File: rtl/branch_flush_ctrl.sv
module branch_flush_ctrl
  import bfc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ex_valid,
  input  logic          ex_taken,
  input  logic          ex_delayed,
  input  logic [AW-1:0] ex_target,
  input  logic          ex_exception,
  input  logic [AW-1:0] ex_pc_next,
  input  logic          dec_valid,
  input  logic          dec_is_imm,
  input  logic          dec_is_branch,
  input  logic          dec_is_brk,
  input  logic          irq_req,
  input  logic          brk_req,
  output logic          flush_pfb,
  output logic          flush_fetch,
  output logic          flush_decode,
  output logic          redirect_valid,
  output logic [AW-1:0] redirect_pc,
  output logic          slot_active,
  output logic          slot_illegal,
  output logic          irq_take,
  output logic          brk_take,
  output logic          esr_ds,
  output logic [AW-1:0] btr,
  output logic [AW-1:0] ret_addr,
  output logic          ret_addr_valid
);

  flush_t        flush;
  logic          arm_slot;
  logic          slot_retire;
  logic [AW-1:0] slot_tgt;
  logic          defer;
  logic          exc_fire;

  assign exc_fire     = ex_valid & ex_exception;
  assign flush_pfb    = flush.pfb;
  assign flush_fetch  = flush.fetch;
  assign flush_decode = flush.decode;

  bfc_flush_unit #(.AW(AW)) flush_i (
    .ex_valid       (ex_valid),
    .ex_taken       (ex_taken),
    .ex_delayed     (ex_delayed),
    .ex_target      (ex_target),
    .flush          (flush),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .arm_slot       (arm_slot)
  );

  bfc_slot_tracker #(.AW(AW)) slot_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .arm_slot      (arm_slot),
    .arm_target    (ex_target),
    .ex_valid      (ex_valid),
    .dec_valid     (dec_valid),
    .dec_is_imm    (dec_is_imm),
    .dec_is_branch (dec_is_branch),
    .dec_is_brk    (dec_is_brk),
    .slot_active   (slot_active),
    .slot_retire   (slot_retire),
    .slot_tgt      (slot_tgt),
    .slot_illegal  (slot_illegal)
  );

  bfc_event_gate gate_i (
    .arm_slot    (arm_slot),
    .slot_active (slot_active),
    .irq_req     (irq_req),
    .brk_req     (brk_req),
    .defer       (defer),
    .irq_take    (irq_take),
    .brk_take    (brk_take)
  );

  bfc_exc_capture #(.AW(AW)) exc_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .exc_fire       (exc_fire),
    .in_slot        (slot_active),
    .slot_tgt       (slot_tgt),
    .pc_next        (ex_pc_next),
    .esr_ds         (esr_ds),
    .btr            (btr),
    .ret_addr       (ret_addr),
    .ret_addr_valid (ret_addr_valid)
  );

endmodule

// File: rtl/bfc_checker.sv
module bfc_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ex_valid,
  input logic          ex_taken,
  input logic          ex_delayed,
  input logic [AW-1:0] ex_target,
  input logic          ex_exception,
  input logic          irq_req,
  input logic          flush_pfb,
  input logic          flush_fetch,
  input logic          flush_decode,
  input logic          redirect_valid,
  input logic [AW-1:0] redirect_pc,
  input logic          slot_active,
  input logic          slot_illegal,
  input logic          irq_take,
  input logic          brk_take,
  input logic          esr_ds,
  input logic [AW-1:0] btr,
  input logic          ret_addr_valid,
  input logic          arm_slot,
  input logic          slot_retire,
  input logic [AW-1:0] slot_tgt,
  input logic          defer
);

  assert_full_flush_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_taken && !ex_delayed) |-> (flush_pfb && flush_fetch && flush_decode));

  assert_redirect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> (redirect_pc == ex_target && ex_valid && ex_taken));

  assert_refill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> ($countones({flush_fetch, flush_decode}) == (ex_delayed ? 1 : 2)));

  assert_keep_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    arm_slot |-> (flush_fetch && !flush_decode && !flush_pfb));

  assert_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ex_valid && ex_taken) |-> (!flush_fetch && !flush_decode && !flush_pfb && !redirect_valid));

  assert_illegal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    slot_illegal |-> arm_slot);

  assert_defer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    defer |-> (!irq_take && !brk_take));

  assert_slot_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
    arm_slot |=> slot_active);

  assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(slot_retire) && !arm_slot && !slot_active && irq_req) |-> irq_take);

  assert_ds_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_retire && ex_exception) |=> (esr_ds && btr == $past(slot_tgt) && !ret_addr_valid));

  assert_ds_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_exception && !slot_active) |=> (!esr_ds && ret_addr_valid && $stable(btr)));

endmodule

bind branch_flush_ctrl bfc_checker #(.AW(AW)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .ex_valid       (ex_valid),
  .ex_taken       (ex_taken),
  .ex_delayed     (ex_delayed),
  .ex_target      (ex_target),
  .ex_exception   (ex_exception),
  .irq_req        (irq_req),
  .flush_pfb      (flush_pfb),
  .flush_fetch    (flush_fetch),
  .flush_decode   (flush_decode),
  .redirect_valid (redirect_valid),
  .redirect_pc    (redirect_pc),
  .slot_active    (slot_active),
  .slot_illegal   (slot_illegal),
  .irq_take       (irq_take),
  .brk_take       (brk_take),
  .esr_ds         (esr_ds),
  .btr            (btr),
  .ret_addr_valid (ret_addr_valid),
  .arm_slot       (arm_slot),
  .slot_retire    (slot_retire),
  .slot_tgt       (slot_tgt),
  .defer          (defer)
);

// File: tb/branch_flush_ctrl_tb_top.sv
module branch_flush_ctrl_tb_top;

  localparam int AW = 32;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ex_valid = 0, ex_taken = 0, ex_delayed = 0, ex_exception = 0;
  logic [AW-1:0] ex_target = '0, ex_pc_next = '0;
  logic dec_valid = 0, dec_is_imm = 0, dec_is_branch = 0, dec_is_brk = 0;
  logic irq_req = 0, brk_req = 0;
  logic flush_pfb, flush_fetch, flush_decode, redirect_valid;
  logic [AW-1:0] redirect_pc, btr, ret_addr;
  logic slot_active, slot_illegal, irq_take, brk_take, esr_ds, ret_addr_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench-side model state
  logic m_open = 0, m_ds = 0, m_seen = 0;
  logic [AW-1:0] m_tgt = '0, m_btr = '0, m_ra = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_flush_ctrl #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ex_valid(ex_valid), .ex_taken(ex_taken),
    .ex_delayed(ex_delayed), .ex_target(ex_target), .ex_exception(ex_exception),
    .ex_pc_next(ex_pc_next), .dec_valid(dec_valid), .dec_is_imm(dec_is_imm),
    .dec_is_branch(dec_is_branch), .dec_is_brk(dec_is_brk), .irq_req(irq_req),
    .brk_req(brk_req), .flush_pfb(flush_pfb), .flush_fetch(flush_fetch),
    .flush_decode(flush_decode), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .slot_active(slot_active), .slot_illegal(slot_illegal),
    .irq_take(irq_take), .brk_take(brk_take), .esr_ds(esr_ds), .btr(btr),
    .ret_addr(ret_addr), .ret_addr_valid(ret_addr_valid)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected combinational outputs, restated from the requirements.
  function automatic logic [2:0] exp_flush(input logic v, input logic t, input logic d);
    logic tk = v & t;
    return {tk & ~d, tk, tk & ~d}; // {pfb, fetch, decode}
  endfunction

  function automatic int stages_refilled(input logic d);
    return d ? 1 : 2;
  endfunction

  task automatic check_comb();
    logic arm;
    logic [2:0] ef;
    arm = ex_valid & ex_taken & ex_delayed;
    ef  = exp_flush(ex_valid, ex_taken, ex_delayed);
    if (ex_valid && ex_taken && !ex_delayed)
      chk(flush_pfb & flush_fetch & flush_decode, "R1 full flush", {flush_pfb, flush_fetch, flush_decode}, 3'b111);
    chk(redirect_valid == (ex_valid & ex_taken), "R2 redirect_valid", redirect_valid, ex_valid & ex_taken);
    if (ex_valid && ex_taken) begin
      chk(redirect_pc == ex_target, "R2 redirect_pc", redirect_pc, ex_target);
      chk(int'(flush_fetch) + int'(flush_decode) == stages_refilled(ex_delayed), "R3 refill stages",
          int'(flush_fetch) + int'(flush_decode), stages_refilled(ex_delayed));
    end
    if (arm)
      chk({flush_pfb, flush_fetch, flush_decode} == 3'b010, "R4 delayed flush", {flush_pfb, flush_fetch, flush_decode}, 3'b010);
    if (!(ex_valid && ex_taken))
      chk({flush_pfb, flush_fetch, flush_decode} == 3'b000, "R5 no flush", {flush_pfb, flush_fetch, flush_decode}, 3'b000);
    chk({flush_pfb, flush_fetch, flush_decode} == ef, "R1/R4/R5 flush set", {flush_pfb, flush_fetch, flush_decode}, ef);
    chk(slot_illegal == (arm & dec_valid & (dec_is_imm | dec_is_branch | dec_is_brk)), "R6 slot_illegal",
        slot_illegal, arm & dec_valid & (dec_is_imm | dec_is_branch | dec_is_brk));
    if (arm || m_open) begin
      chk({irq_take, brk_take} == 2'b00, "R7 deferral", {irq_take, brk_take}, 2'b00);
    end else begin
      chk({irq_take, brk_take} == {irq_req, brk_req}, "R8 accept", {irq_take, brk_take}, {irq_req, brk_req});
    end
  endtask

  task automatic check_regs();
    chk(slot_active == m_open, "R7 slot_active", slot_active, m_open);
    chk(esr_ds == m_ds, "R9/R10 esr_ds", esr_ds, m_ds);
    chk(btr == m_btr, "R9 btr", btr, m_btr);
    chk(ret_addr == m_ra, "R10 ret_addr", ret_addr, m_ra);
    chk(ret_addr_valid == (m_seen & ~m_ds), "R10 ret_addr_valid", ret_addr_valid, m_seen & ~m_ds);
  endtask

  task automatic model_clock();
    logic arm;
    arm = ex_valid & ex_taken & ex_delayed;
    if (ex_valid && ex_exception) begin
      m_seen = 1'b1;
      if (m_open) begin m_ds = 1'b1; m_btr = m_tgt; end
      else begin m_ds = 1'b0; m_ra = ex_pc_next; end
    end
    if (arm) begin m_open = 1'b1; m_tgt = ex_target; end
    else if (m_open && ex_valid) m_open = 1'b0;
  endtask

  task automatic step(input logic v, input logic t, input logic d, input logic [AW-1:0] tgt,
                      input logic exc, input logic [AW-1:0] pcn, input logic [3:0] dec,
                      input logic irq, input logic brk);
    @(negedge clk);
    ex_valid = v; ex_taken = t; ex_delayed = d; ex_target = tgt;
    ex_exception = exc; ex_pc_next = pcn;
    {dec_valid, dec_is_imm, dec_is_branch, dec_is_brk} = dec;
    irq_req = irq; brk_req = brk;
    #1 check_comb();
    @(posedge clk);
    model_clock();
    #1 check_regs();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    chk(slot_active == 0 && esr_ds == 0 && ret_addr_valid == 0, "R11 reset flags",
        {slot_active, esr_ds, ret_addr_valid}, 3'b000);
    chk(btr == '0 && ret_addr == '0, "R11 reset regs", {btr, ret_addr}, 64'h0);
    @(negedge clk) rst_n = 1'b1;

    // Directed: ordinary taken branch (R1, R3)
    step(1, 1, 0, 32'h0000_1000, 0, 32'h4, 4'b1000, 0, 0);
    // Delayed taken, legal slot, irq pending across slot (R4, R7)
    step(1, 1, 1, 32'h0000_2000, 0, 32'h8, 4'b1000, 1, 1);
    // Slot stalls one cycle (ex_valid low) then retires (R7)
    step(0, 0, 0, 32'h0, 0, 32'h0, 4'b0000, 1, 1);
    step(1, 0, 0, 32'h0, 0, 32'hC, 4'b1000, 1, 1);
    // First cycle after retire: accepted (R8)
    step(1, 0, 0, 32'h0, 0, 32'h10, 4'b1000, 1, 1);
    // Delayed branch with each forbidden slot class (R6)
    step(1, 1, 1, 32'h0000_3000, 0, 32'h14, 4'b1100, 0, 0);
    step(1, 0, 0, 32'h0, 0, 32'h0, 4'b1000, 0, 0);
    step(1, 1, 1, 32'h0000_3100, 0, 32'h18, 4'b1010, 0, 0);
    step(1, 0, 0, 32'h0, 0, 32'h0, 4'b1000, 0, 0);
    step(1, 1, 1, 32'h0000_3200, 0, 32'h1C, 4'b1001, 0, 0);
    // Slot raises an exception (R9)
    step(1, 0, 0, 32'h0, 1, 32'h3204, 4'b1000, 0, 0);
    // Not-taken delayed branch: no flush, no slot (R5)
    step(1, 0, 1, 32'h0000_4000, 0, 32'h20, 4'b1000, 1, 0);
    // Non-slot exception (R10)
    step(1, 0, 0, 32'h0, 1, 32'h0000_5004, 4'b1000, 0, 1);

    // Constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      logic v, t, d, e, iq, bk;
      logic [3:0] dc;
      v  = ($urandom % 100) < 80;
      t  = ($urandom % 100) < 35;
      d  = ($urandom % 2) == 1;
      e  = ($urandom % 100) < 12;
      iq = ($urandom % 100) < 40;
      bk = ($urandom % 100) < 20;
      dc = {($urandom % 100) < 85, ($urandom % 100) < 10, ($urandom % 100) < 10, ($urandom % 100) < 10};
      step(v, t, d, $urandom & 32'hFFFF_FFFC, e, $urandom & 32'hFFFF_FFFC, dc, iq, bk);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule